// File: doc/BRIEF.md
# Scanline XOR Area Fill Unit

This stage sits between the bitwise logic datapath of a rectangle-copy engine and the destination write port. It turns outline bitmaps into solid shapes. Each row of a polygon outline has one set bit where an edge crosses it. A running fill carry flips at every set bit, so every pixel between two crossings on a scanline is filled in.

Words enter the unit rightmost-first and rows run bottom-to-top, so the engine must operate in descending order. Inside a word the carry moves from bit 0, the rightmost pixel, up to the most significant bit, the leftmost pixel. Whatever carry is left after the last bit starts the next word of the same row. When a word is flagged as the first of a row, the carry is loaded from a programmed initial value.

There are two fill variants. The inclusive variant keeps both boundary pixels of each span. The exclusive variant keeps only one edge of each span. With neither variant selected the data passes through untouched. Each result appears one clock after its input word.

Top module: `span_fill_unit`

## Requirements
- R1: While reset is asserted, `word_out` is all zeros and `out_valid` is 0.
- R2: `out_valid` is 1 exactly in the cycle after a cycle with `word_valid` high. `word_out` then holds the result for that word.
- R3: On a word with `row_first`=1, the carry at bit 0 (the rightmost pixel) is `carry_init`. Any carry left from earlier words is discarded.
- R4: Inclusive mode (`fill_incl`=1). Let c_i be the start carry XOR the XOR of input bits 0..i-1. Output bit i is input bit i OR c_i.
- R5: Exclusive mode (`fill_excl`=1, `fill_incl`=0). Output bit i is the start carry XOR the XOR of input bits 0..i. Two adjacent set bits therefore cancel each other.
- R6: On a word that does not start a row, with fill on, the start carry is the carry after the most significant bit of the previous valid word.
- R7: With both fill bits at 0, `word_out` equals the input word. The carry register takes the word's start carry: `carry_init` on a row-first word, otherwise its held value.
- R8: With both fill bits set, inclusive mode is used.
- R9: Cycles with `word_valid`=0 leave the carry unchanged and do not change `word_out`. This holds whatever the other inputs are in those cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| word_in | input | WORD_W | Data word from the logic datapath; bit 0 is the rightmost pixel |
| word_valid | input | 1 | Word strobe |
| row_first | input | 1 | Marks the first (rightmost) word of a row |
| fill_incl | input | 1 | Inclusive fill enable |
| fill_excl | input | 1 | Exclusive fill enable |
| carry_init | input | 1 | Carry value loaded at the start of each row |
| word_out | output | WORD_W | Filled word, registered |
| out_valid | output | 1 | Marks `word_out` as new |

## Verification
The assertions assume that the mode and `carry_init` inputs are meaningful only in cycles where `word_valid` is high. They also assume that each row starts with a word flagged `row_first`. The stimulus respects both assumptions. Every row starts with a flagged word, and the mode inputs are held steady across the words of a row. Idle cycles are inserted mid-row with arbitrary values on `row_first`, `carry_init` and the mode pins, to show that these inputs have no effect while the strobe is low. A reduced 8-bit word is swept over every value, every start carry and every mode combination. Multi-word rows drawn from a shift-register sequence then cover how the carry crosses word boundaries.

// File: rtl/span_fill_pkg.sv
package span_fill_pkg;

  typedef enum logic [1:0] {
    FILL_OFF  = 2'd0,
    FILL_INCL = 2'd1,
    FILL_EXCL = 2'd2
  } fill_mode_e;

  function automatic fill_mode_e decode_mode(input logic incl, input logic excl);
    if (incl)      return FILL_INCL;
    else if (excl) return FILL_EXCL;
    else           return FILL_OFF;
  endfunction

endpackage

// File: rtl/span_fill_chain.sv
module span_fill_chain
  import span_fill_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [WORD_W-1:0] data_i,
  input  logic              carry_i,
  input  fill_mode_e        mode_i,
  output logic [WORD_W-1:0] data_o,
  output logic              carry_o
);

  localparam logic [WORD_W-1:0] ONE = {{(WORD_W-1){1'b0}}, 1'b1};

  generate
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
      localparam logic [WORD_W-1:0] LOW_MASK = (ONE << i) - ONE;
      logic before_c;
      logic after_c;
      assign before_c = carry_i ^ (^(data_i & LOW_MASK));
      assign after_c  = before_c ^ data_i[i];
      assign data_o[i] = (mode_i == FILL_INCL) ? (data_i[i] | before_c) :
                         (mode_i == FILL_EXCL) ? after_c : data_i[i];
    end
  endgenerate

  assign carry_o = carry_i ^ (^data_i);

endmodule

// File: rtl/span_fill_carry.sv
module span_fill_carry (
  input  logic clk,
  input  logic rst_n,
  input  logic word_valid,
  input  logic row_first,
  input  logic carry_init,
  input  logic fill_on,
  input  logic chain_carry,
  output logic carry_start
);

  logic carry_q;
  logic carry_d;

  assign carry_start = row_first ? carry_init : carry_q;

  always_comb begin
    carry_d = carry_q;
    if (word_valid) begin
      carry_d = fill_on ? chain_carry : carry_start;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry_q <= 1'b0;
    else        carry_q <= carry_d;
  end

  // R9: idle cycles leave the carry alone
  a_r9_carry_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> $stable(carry_q));

  // R7: with fill off a row-first word leaves the programmed value behind
  a_r7_off_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && row_first && !fill_on) |=> (carry_q == $past(carry_init)));

endmodule

// File: rtl/span_fill_unit.sv
module span_fill_unit
  import span_fill_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] word_in,
  input  logic              word_valid,
  input  logic              row_first,
  input  logic              fill_incl,
  input  logic              fill_excl,
  input  logic              carry_init,
  output logic [WORD_W-1:0] word_out,
  output logic              out_valid
);

  fill_mode_e        mode;
  logic              carry_start;
  logic              chain_carry;
  logic [WORD_W-1:0] filled;
  logic [WORD_W-1:0] out_d;
  logic [WORD_W-1:0] out_q;
  logic              vld_q;

  assign mode = decode_mode(fill_incl, fill_excl);

  span_fill_carry u_carry (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .row_first  (row_first),
    .carry_init (carry_init),
    .fill_on    (mode != FILL_OFF),
    .chain_carry(chain_carry),
    .carry_start(carry_start)
  );

  span_fill_chain #(.WORD_W(WORD_W)) u_chain (
    .data_i (word_in),
    .carry_i(carry_start),
    .mode_i (mode),
    .data_o (filled),
    .carry_o(chain_carry)
  );

  always_comb begin
    out_d = out_q;
    if (word_valid) out_d = filled;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else begin
      out_q <= out_d;
      vld_q <= word_valid;
    end
  end

  assign word_out  = out_q;
  assign out_valid = vld_q;

  // R2: one-cycle strobe
  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> out_valid);
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> !out_valid);

  // R7: pass-through
  a_r7_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && !fill_incl && !fill_excl) |=> (word_out == $past(word_in)));

  // R4/R8: inclusive output keeps every outline bit
  a_r4_keeps_outline: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && fill_incl) |=> ((word_out & $past(word_in)) == $past(word_in)));

  // R3/R5: empty word at row start in exclusive mode is a solid copy of the initial carry
  a_r5_empty_row_start: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && fill_excl && !fill_incl && row_first && (word_in == '0))
      |=> (word_out == {WORD_W{$past(carry_init)}}));

  // R9: output stable through idle cycles
  a_r9_out_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |=> $stable(word_out));

endmodule

// File: tb/span_fill_unit_bench.sv
module span_fill_unit_bench;

  localparam int BW = 8;

  logic          clk;
  logic          rst_n;
  logic [BW-1:0] word_in;
  logic          word_valid;
  logic          row_first;
  logic          fill_incl;
  logic          fill_excl;
  logic          carry_init;
  logic [BW-1:0] word_out;
  logic          out_valid;

  int checks;
  int failures;
  logic model_carry;
  logic [BW-1:0] last_out;
  logic [15:0] lfsr;

  span_fill_unit #(.WORD_W(BW)) u_span_fill_unit (
    .clk(clk), .rst_n(rst_n), .word_in(word_in), .word_valid(word_valid),
    .row_first(row_first), .fill_incl(fill_incl), .fill_excl(fill_excl),
    .carry_init(carry_init), .word_out(word_out), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  initial begin
    for (int n = 0; n < 200000; n++) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  // returns {carry_out, word}
  function automatic logic [BW:0] fill_model(input logic [BW-1:0] w, input logic start,
                                              input logic incl, input logic excl);
    logic c;
    logic b;
    logic [BW-1:0] o;
    c = start;
    for (int i = 0; i < BW; i++) begin
      b = c;
      c = c ^ w[i];
      o[i] = incl ? (w[i] | b) : (excl ? c : w[i]);
    end
    if (!(incl || excl)) c = start;
    return {c, o};
  endfunction

  task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [BW-1:0] w, input logic rf, input logic inc,
                      input logic exc, input logic ci, input string tag);
    logic start;
    logic [BW:0] r;
    start = rf ? ci : model_carry;
    r = fill_model(w, start, inc, exc);
    model_carry = r[BW];
    word_in = w; word_valid = 1'b1; row_first = rf;
    fill_incl = inc; fill_excl = exc; carry_init = ci;
    @(posedge clk); #2;
    word_valid = 1'b0;
    check({tag, " R2 valid"}, {7'd0, out_valid}, 8'd1);
    check(tag, word_out, r[BW-1:0]);
    last_out = r[BW-1:0];
  endtask

  task automatic idle(input logic junk);
    word_valid = 1'b0; row_first = junk; carry_init = ~junk;
    fill_incl = junk; fill_excl = ~junk; word_in = {BW{junk}};
    @(posedge clk); #2;
    check("R2 idle valid", {7'd0, out_valid}, 8'd0);
    check("R9 idle output", word_out, last_out);
  endtask

  function automatic string mode_tag(input logic inc, input logic exc);
    if (inc && exc) return "R8";
    if (inc)        return "R4";
    if (exc)        return "R5";
    return "R7";
  endfunction

  initial begin
    checks = 0; failures = 0; model_carry = 1'b0; last_out = '0;
    lfsr = 16'hACE1;
    word_in = '0; word_valid = 1'b0; row_first = 1'b0;
    fill_incl = 1'b0; fill_excl = 1'b0; carry_init = 1'b0;
    rst_n = 1'b0;
    @(posedge clk); #2;
    word_valid = 1'b1; word_in = 8'hFF;
    @(posedge clk); #2;
    check("R1 reset word", word_out, 8'h00);
    check("R1 reset valid", {7'd0, out_valid}, 8'd0);
    word_valid = 1'b0;
    rst_n = 1'b1;
    @(posedge clk); #2;

    // exhaustive row-start words (R3 plus each mode)
    for (int m = 0; m < 4; m++) begin
      for (int ci = 0; ci < 2; ci++) begin
        for (int w = 0; w < 256; w++) begin
          send(w[BW-1:0], 1'b1, m[0], m[1], ci[0],
               {"R3 ", mode_tag(m[0], m[1])});
        end
      end
    end

    // directed: double-width edge cancels (R5)
    send(8'b0000_0110, 1'b1, 1'b0, 1'b1, 1'b0, "R5 double edge");
    check("R5 double edge value", word_out, 8'b0000_0010);

    // directed: carry held at row-start value while fill is off (R7)
    send(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1, "R7 off row start");
    send(8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R7 held carry");
    check("R7 held carry value", word_out, 8'hFF);

    // directed: carry crosses word boundary (R6)
    send(8'h01, 1'b1, 1'b0, 1'b1, 1'b0, "R6 word a");
    send(8'h00, 1'b0, 1'b0, 1'b1, 1'b1, "R6 word b");
    check("R6 carried fill", word_out, 8'hFF);

    // multi-word rows with idle gaps (R6, R9)
    for (int row = 0; row < 300; row++) begin
      logic inc;
      logic exc;
      logic ci;
      inc = row[0]; exc = row[1]; ci = row[2] ^ row[4];
      for (int k = 0; k < 4; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        if (k == 2 && row[3]) begin
          idle(lfsr[0]);
          send(lfsr[BW-1:0], 1'b0, inc, exc, ~ci, {"R9 after idle ", mode_tag(inc, exc)});
        end else begin
          send(lfsr[BW-1:0], (k == 0), inc, exc, ci,
               (k == 0) ? {"R3 ", mode_tag(inc, exc)} : {"R6 ", mode_tag(inc, exc)});
        end
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule